// File: doc/BRIEF.md
# Serial ADC Sample Readout Controller

This block is the host side of a three-wire link to a 12-bit successive-approximation converter. It drives an active-low chip select and a data clock, and it receives the converter's serial data line. A frame starts on a one-cycle start request, or on an internal rate tick when the free-running mode is on. The block then lowers chip select and toggles the data clock. It lets the sampling clocks and the zero null bit go by, and captures the result bits most significant first on the rising clock edges. When the frame ends it raises chip select and presents the word with a one-cycle valid strobe.

A frame can be cut short after n data bits, so a monitor loop can stop reading once it has the bits it needs. The received bits stay left-aligned in the word, the missing low bits read as zero, and the number of valid bits is reported next to the word. The half-period of the data clock is set in system clock cycles, so the serial clock can be kept inside the converter's allowed frequency and pulse-width limits. Chip select is then held high for a fixed number of data-clock periods before the next frame can start.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no frame started, `adc_cs_n_o` is 1, `adc_sclk_o` is 1, `valid_o` is 0 and `busy_o` is 0.
- R2: A start request seen while idle lowers `adc_cs_n_o` and raises `busy_o` on the next clock edge. A frame carrying n data bits then has exactly n+2 falling edges of `adc_sclk_o` while `adc_cs_n_o` is low.
- R3: `adc_sdata_i` is sampled when `adc_sclk_o` rises. The samples taken in periods 1 and 2 (the sampling period and the null bit) are discarded. The sample taken in period k (k >= 3) is stored in word bit 14-k, so the first data bit lands in bit 11.
- R4: `bit_len_i` selects n data bits, from 1 to 12. A value of 0 or above 12 means 12. The n received bits are the top n bits of `word_o`, the lower 12-n bits are 0, and `nbits_o` equals n.
- R5: `valid_o` is high for exactly one cycle per frame. It rises on the same edge on which `adc_cs_n_o` returns high, and `word_o`/`nbits_o` are valid in that cycle.
- R6: After `adc_cs_n_o` rises, `busy_o` stays high for 2·GAP_PERIODS·d cycles, where d is the effective half-period. With a start request held high, chip select is high for exactly 2·GAP_PERIODS·d+1 cycles between frames.
- R7: A start request or rate tick that arrives while `busy_o` is high is dropped. It does not start a later frame.
- R8: With `auto_en_i` high, a rate tick occurs every `auto_period_i` cycles. A value of 0 counts as 1. Each tick that finds the block idle starts a frame, so chip-select falling edges are spaced `auto_period_i` cycles apart.
- R9: Within a frame, each high and low phase of `adc_sclk_o` lasts d = `half_div_i` system cycles, where a value of 0 means 1. `adc_sclk_o` is 1 whenever `adc_cs_n_o` is 1.
- R10: The code is passed through as straight binary with no change: the serial codes 0x000, 0x800 and 0xFFF appear unchanged on `word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to start a frame |
| auto_en_i | input | 1 | Enables the free-running rate tick |
| auto_period_i | input | PER_W | Rate tick period in system cycles |
| half_div_i | input | DIV_W | Data clock half-period in system cycles, latched at frame start |
| bit_len_i | input | LEN_W | Number of data bits to read, latched at frame start |
| adc_sdata_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low chip select to the converter |
| adc_sclk_o | output | 1 | Data clock to the converter, idle high |
| word_o | output | DATA_W | Received code, left-aligned, zero-filled |
| nbits_o | output | LEN_W | Number of valid bits in `word_o` |
| valid_o | output | 1 | One-cycle strobe marking a new word |
| busy_o | output | 1 | High from chip select falling until the high gap ends |

## Verification
The embedded properties assume that the converter changes its data line only after a falling data-clock edge, so the value is stable by the following rising edge. They also assume that the reset input is released by the system clock. The bench's converter model updates its line only on falling clock edges while chip select is low, and holds it high otherwise, so any sample taken too early shows up as a wrong bit. The length and divider inputs are changed only between frames, and the rate period is kept longer than one frame plus its gap, so each tick finds the block idle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_DONE  = 3'd4,
    ST_GAP   = 3'd5
  } seq_state_e;

endpackage

// File: rtl/adc_rd_div.sv
module adc_rd_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (cnt_q == div_i - DIV_W'(1)) begin
      cnt_d  = '0;
      tick_o = 1'b1;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (div_i != '0)); // R9

endmodule

// File: rtl/adc_rd_rate.sv
module adc_rd_rate #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] eff_per;

  always_comb begin
    eff_per = (period_i == '0) ? PER_W'(1) : period_i;
    tick_o  = 1'b0;
    cnt_d   = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (cnt_q >= eff_per - PER_W'(1)) begin
      cnt_d  = '0;
      tick_o = 1'b1;
    end else begin
      cnt_d = cnt_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_RATE_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> en_i); // R8

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int DATA_W = 12,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] data_o
);

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    logic bit_d;
    always_comb begin
      bit_d = data_o[gi];
      if (clr_i)                              bit_d = 1'b0;
      else if (cap_i && (pos_i == POS_W'(gi))) bit_d = din_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_o[gi] <= 1'b0;
      else        data_o[gi] <= bit_d;
    end
  end

  AST_CAP_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |-> (int'(pos_i) < DATA_W)); // R3

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int DIV_W       = 8,
  parameter int PER_W       = 16,
  parameter int LEN_W       = 4,
  parameter int GAP_PERIODS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              auto_en_i,
  input  logic [PER_W-1:0]  auto_period_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [LEN_W-1:0]  bit_len_i,
  input  logic              adc_sdata_i,
  output logic              adc_cs_n_o,
  output logic              adc_sclk_o,
  output logic [DATA_W-1:0] word_o,
  output logic [LEN_W-1:0]  nbits_o,
  output logic              valid_o,
  output logic              busy_o
);

  localparam int CNT_W      = $clog2(DATA_W + 3);
  localparam int GAP_HALVES = 2 * GAP_PERIODS;
  localparam int GAP_W      = $clog2(GAP_HALVES + 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  seq_state_e        st_q, st_d;
  logic              cs_q, cs_d;
  logic              sclk_q, sclk_d;
  logic [CNT_W-1:0]  per_q, per_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic [LEN_W-1:0]  nbits_q, nbits_d;

  logic              rate_tick, half_tick, trig, div_run;
  logic              cap_en, shift_clr, last_per;
  logic [CNT_W-1:0]  cap_pos;
  logic [LEN_W-1:0]  eff_len;
  logic [DIV_W-1:0]  eff_div;
  logic [DATA_W-1:0] shreg;

  adc_rd_rate #(.PER_W(PER_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (auto_en_i),
    .period_i (auto_period_i),
    .tick_o   (rate_tick)
  );

  adc_rd_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (div_run),
    .div_i  (div_q),
    .tick_o (half_tick)
  );

  adc_rd_shift #(.DATA_W(DATA_W), .POS_W(CNT_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (shift_clr),
    .cap_i  (cap_en),
    .pos_i  (cap_pos),
    .din_i  (adc_sdata_i),
    .data_o (shreg)
  );

  always_comb begin
    eff_len = ((bit_len_i == '0) || (int'(bit_len_i) > DATA_W)) ? LEN_W'(DATA_W) : bit_len_i;
    eff_div = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
    trig    = start_i | rate_tick;
    div_run = (st_q == ST_SETUP) || (st_q == ST_LOW) || (st_q == ST_HIGH) || (st_q == ST_GAP);
    last_per = (per_q == (CNT_W'(len_q) + CNT_W'(2)));
    cap_pos  = CNT_W'(DATA_W + 2) - per_q;
    cap_en   = (st_q == ST_LOW) && half_tick && (per_q >= CNT_W'(3));
  end

  // next-state process
  always_comb begin
    st_d      = st_q;
    cs_d      = cs_q;
    sclk_d    = sclk_q;
    per_d     = per_q;
    gap_d     = gap_q;
    len_d     = len_q;
    div_d     = div_q;
    valid_d   = 1'b0;
    word_d    = word_q;
    nbits_d   = nbits_q;
    shift_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (trig) begin
          st_d      = ST_SETUP;
          cs_d      = 1'b0;
          per_d     = '0;
          len_d     = eff_len;
          div_d     = eff_div;
          shift_clr = 1'b1;
        end
      end
      ST_SETUP: begin
        if (half_tick) begin
          sclk_d = 1'b0;
          per_d  = CNT_W'(1);
          st_d   = ST_LOW;
        end
      end
      ST_LOW: begin
        if (half_tick) begin
          sclk_d = 1'b1;
          st_d   = last_per ? ST_DONE : ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (half_tick) begin
          sclk_d = 1'b0;
          per_d  = per_q + CNT_W'(1);
          st_d   = ST_LOW;
        end
      end
      ST_DONE: begin
        cs_d    = 1'b1;
        valid_d = 1'b1;
        word_d  = shreg;
        nbits_d = len_q;
        gap_d   = '0;
        st_d    = ST_GAP;
      end
      ST_GAP: begin
        if (half_tick) begin
          if (gap_q == GAP_W'(GAP_HALVES - 1)) st_d = ST_IDLE;
          else                                 gap_d = gap_q + GAP_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= ST_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      per_q   <= '0;
      gap_q   <= '0;
      len_q   <= LEN_W'(DATA_W);
      div_q   <= DIV_W'(1);
      valid_q <= 1'b0;
      word_q  <= '0;
      nbits_q <= '0;
    end else begin
      st_q    <= st_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      per_q   <= per_d;
      gap_q   <= gap_d;
      len_q   <= len_d;
      div_q   <= div_d;
      valid_q <= valid_d;
      word_q  <= word_d;
      nbits_q <= nbits_d;
    end
  end

  assign adc_cs_n_o = cs_q;
  assign adc_sclk_o = sclk_q;
  assign valid_o    = valid_q;
  assign word_o     = word_q;
  assign nbits_o    = nbits_q;
  assign busy_o     = (st_q != ST_IDLE);

  logic [DATA_W-1:0] fill_mask;
  assign fill_mask = {DATA_W{1'b1}} >> nbits_o;

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adc_cs_n_o |-> adc_sclk_o); // R9
  AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !adc_cs_n_o |-> busy_o); // R2
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o |=> !valid_o); // R5
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(adc_cs_n_o) |-> valid_o); // R5
  AST_NBITS_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o |-> (nbits_o != '0) && (int'(nbits_o) <= DATA_W)); // R4
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o |-> ((word_o & fill_mask) == '0)); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(adc_cs_n_o) |-> !$past(busy_o)); // R7

endmodule

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, auto_en, sdo;
  logic [15:0] auto_per;
  logic [7:0]  half_div;
  logic [3:0]  bit_len;
  logic        cs_n, sclk, valid, busy;
  logic [11:0] word;
  logic [3:0]  nbits;

  always #5 clk = ~clk;

  adc_rd_ctrl u_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .auto_en_i(auto_en),
    .auto_period_i(auto_per), .half_div_i(half_div), .bit_len_i(bit_len),
    .adc_sdata_i(sdo), .adc_cs_n_o(cs_n), .adc_sclk_o(sclk),
    .word_o(word), .nbits_o(nbits), .valid_o(valid), .busy_o(busy)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  typedef struct { logic [11:0] w; int n; } exp_t;
  exp_t exp_q[$];

  // converter model: updates its line only on falling clock edges
  logic [11:0] mcode;
  int          mfalls;
  always @(negedge cs_n) begin mfalls = 0; sdo = 1'b1; end
  always @(posedge cs_n) sdo = 1'b1;
  always @(negedge sclk) begin
    if (!cs_n) begin
      mfalls++;
      if (mfalls == 1)       sdo = 1'b1;
      else if (mfalls == 2)  sdo = 1'b0;
      else if (mfalls <= 14) sdo = mcode[14 - mfalls];
      else                   sdo = 1'b0;
    end
  end

  // monitor / scoreboard
  int cyc = 0, frames = 0, fall_prev = 0, fall_cur = 0;
  int hi_run = 0, last_hi = 0, gap_cnt = 0;
  int run = 0, hmin = 999, hmax = 0;
  bit seen = 0, prev_cs = 1'b1, prev_sclk = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_n && !sclk) chk(1'b0, "R9", "clock low while select high", 0, 1);
      if (valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected valid", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(word == e.w, "R3/R4/R10", "word", int'(word), int'(e.w));
          chk(int'(nbits) == e.n, "R4", "nbits", int'(nbits), e.n);
        end
      end
      if (prev_cs && !cs_n) begin
        frames++;
        fall_prev = fall_cur; fall_cur = cyc;
        last_hi = hi_run; hi_run = 0;
        seen = 0; hmin = 999; hmax = 0; gap_cnt = 0;
      end
      if (cs_n) hi_run++;
      if (cs_n && busy) gap_cnt++;
      if (!cs_n) begin
        if (sclk != prev_sclk) begin
          if (seen) begin
            if (run < hmin) hmin = run;
            if (run > hmax) hmax = run;
          end
          seen = 1; run = 1;
        end else run++;
      end
      prev_cs = cs_n; prev_sclk = sclk;
    end
  end

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 20000) begin @(negedge clk); g++; end
    chk(g < 20000, "R6", "frame never ended", g, 0);
  endtask

  task automatic do_frame(input logic [11:0] code, input int len, input int div, input bit poke);
    int el, ed, f0;
    exp_t e;
    el = (len == 0 || len > 12) ? 12 : len;
    ed = (div == 0) ? 1 : div;
    mcode = code; bit_len = 4'(len); half_div = 8'(div);
    e.w = code & (12'hFFF << (12 - el)); e.n = el;
    exp_q.push_back(e);
    f0 = frames;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!cs_n && busy, "R2", "select low and busy after start", int'({cs_n, busy}), 1);
    if (poke) begin
      repeat (6 * ed) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wait_idle();
    chk(mfalls == el + 2, "R2", "falling clock edges", mfalls, el + 2);
    chk(hmin == ed && hmax == ed, "R9", "half period", hmax * 1000 + hmin, ed * 1000 + ed);
    chk(gap_cnt == 2 * ed, "R6", "busy after select rise", gap_cnt, 2 * ed);
    chk(exp_q.size() == 0, "R5", "words pending", exp_q.size(), 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(frames == f0 + 1 && cs_n, "R7", "frames after ignored start", frames - f0, 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; auto_en = 1'b0; auto_per = 16'd80;
    half_div = 8'd1; bit_len = 4'd12; mcode = '0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1", "reset cs_n", int'(cs_n), 1);
    chk(sclk == 1'b1, "R1", "reset sclk", int'(sclk), 1);
    chk(valid == 1'b0, "R1", "reset valid", int'(valid), 0);
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_n && sclk && !busy && !valid, "R1", "idle after release",
        int'({cs_n, sclk, busy, valid}), 4'b1100);

    // R10 straight binary, full length, several dividers
    do_frame(12'h000, 12, 1, 0);
    do_frame(12'h800, 12, 2, 0);
    do_frame(12'hFFF, 12, 1, 0);
    do_frame(12'hA5C, 12, 3, 0);
    // R4 short cycles and length decode
    do_frame(12'hB6D, 3, 2, 0);
    do_frame(12'hB6D, 4, 1, 0);
    do_frame(12'h9F1, 8, 1, 0);
    do_frame(12'hFFF, 1, 1, 0);
    do_frame(12'h5A5, 0, 1, 0);
    do_frame(12'h3C3, 15, 2, 0);
    // R9 divider of zero behaves as one
    do_frame(12'h123, 12, 0, 0);
    // R7 start during a frame is dropped
    do_frame(12'h6E9, 12, 2, 1);

    // R6 held start: select high time between frames
    begin
      exp_t e;
      int f0, g;
      mcode = 12'h4D2; bit_len = 4'd5; half_div = 8'd2;
      e.w = 12'h4D2 & 12'hF80; e.n = 5;
      exp_q.push_back(e); exp_q.push_back(e);
      f0 = frames; g = 0;
      @(negedge clk) start = 1'b1;
      while (frames < f0 + 2 && g < 5000) begin @(negedge clk); g++; end
      start = 1'b0;
      wait_idle();
      chk(last_hi == 2 * 2 + 1, "R6", "select high between frames", last_hi, 5);
      chk(exp_q.size() == 0, "R5", "words pending", exp_q.size(), 0);
    end

    // R8 free-running rate tick
    begin
      exp_t e;
      int f0, g;
      mcode = 12'h7A1; bit_len = 4'd12; half_div = 8'd1; auto_per = 16'd80;
      e.w = 12'h7A1; e.n = 12;
      repeat (3) exp_q.push_back(e);
      f0 = frames; g = 0;
      @(negedge clk) auto_en = 1'b1;
      while (frames < f0 + 3 && g < 5000) begin @(negedge clk); g++; end
      auto_en = 1'b0;
      wait_idle();
      chk(fall_cur - fall_prev == 80, "R8", "rate spacing", fall_cur - fall_prev, 80);
      chk(exp_q.size() == 0, "R8", "auto words pending", exp_q.size(), 0);
    end

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule